// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder/Subtractor

This block adds or subtracts two two's-complement operands in one purely combinational pass. The operand width is split into equal groups. Each group forms per-bit generate and propagate terms and works out its internal carries as flat two-level expressions of those terms and of the group's carry-in. It also reports a group generate and a group propagate. A second lookahead level applies the same equations to the group pairs. It produces the carry into every group except the first, and the final carry-out. No carry ripples from bit to bit or from group to group.

A single control input picks the operation. When it is high, the second operand is inverted bit by bit and the carry-in is forced to one, so the same carry network computes the difference. The raw carry-out is passed through unchanged: after a subtraction, a one means no borrow occurred. A signed overflow flag is derived by comparing the carry into the sign bit with the carry out of it.

With the default parameters the block is 16 bits wide and built from four 4-bit groups.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_en` = 0, `sum_out` equals (`a_in` + `b_in`) modulo 2^W.
- R2: With `sub_en` = 1, `sum_out` equals (`a_in` - `b_in`) modulo 2^W.
- R3: `carry_out` is the carry out of bit W-1. For an addition it is bit W of the unsigned sum. For a subtraction it is 1 exactly when `a_in` >= `b_in` as unsigned numbers.
- R4: `ovf_out` is 1 exactly when the signed result of the selected operation falls outside [-2^(W-1), 2^(W-1)-1].
- R5: An all-ones operand plus one gives `sum_out` = 0 and `carry_out` = 1 with no overflow. 0x7FFF plus 1 gives 0x8000 with `ovf_out` = 1.
- R6: Subtracting zero returns `a_in` with `carry_out` = 1 and `ovf_out` = 0. Subtracting an operand from itself gives 0 with `carry_out` = 1.
- R7: R1 to R4 hold for any W that is a multiple of GW with at least two groups. Example: W = 8, GW = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand (minuend when subtracting) |
| b_in | input | W | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| sum_out | output | W | Result of the selected operation, modulo 2^W |
| carry_out | output | 1 | Raw carry out of the most significant bit |
| ovf_out | output | 1 | Signed overflow of the selected operation |

## Verification
Whenever the inputs are known, the bound checker compares the following against a wide arithmetic model of the operation:
- the result together with the carry-out;
- the overflow flag, taken from the operand and result sign bits;
- the self-subtraction case.

These checks therefore cover every vector the bench applies. The bench scenarios show what a single vector cannot:
- that the grouped carry network is correct across the whole input space of a narrow 8-bit configuration, swept exhaustively for both operations;
- that carry chains spanning every group boundary resolve correctly at full width, including the signed corner values.

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int W  = 16,
  parameter int GW = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub_en,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         ovf_out
);
  localparam int NG = W / GW;

  logic [W-1:0]  b_eff, bit_g, bit_p, bit_cin;
  logic [NG-1:0] grp_g, grp_p, grp_cin;
  logic [NG:1]   lv2_c;

  assign b_eff = b_in ^ {W{sub_en}};
  assign bit_g = a_in & b_eff;
  assign bit_p = a_in ^ b_eff;

  for (genvar gi = 0; gi < NG; gi++) begin : g_slice
    logic [GW-1:0] sg, sp, lc;
    logic          gg, gp;
    assign sg = bit_g[gi*GW +: GW];
    assign sp = bit_p[gi*GW +: GW];

    always_comb begin
      for (int k = 0; k < GW; k++) begin
        logic pc, t;
        pc = grp_cin[gi];
        for (int j = 0; j < k; j++) pc = pc & sp[j];
        lc[k] = pc;
        for (int j = 0; j < k; j++) begin
          t = sg[j];
          for (int m = j + 1; m < k; m++) t = t & sp[m];
          lc[k] = lc[k] | t;
        end
      end
      gg = 1'b0;
      gp = 1'b1;
      for (int j = 0; j < GW; j++) begin
        logic t;
        t = sg[j];
        for (int m = j + 1; m < GW; m++) t = t & sp[m];
        gg = gg | t;
        gp = gp & sp[j];
      end
    end

    assign bit_cin[gi*GW +: GW] = lc;
    assign grp_g[gi] = gg;
    assign grp_p[gi] = gp;
  end

  always_comb begin
    for (int k = 1; k <= NG; k++) begin
      logic pc, t;
      pc = sub_en;
      for (int j = 0; j < k; j++) pc = pc & grp_p[j];
      lv2_c[k] = pc;
      for (int j = 0; j < k; j++) begin
        t = grp_g[j];
        for (int m = j + 1; m < k; m++) t = t & grp_p[m];
        lv2_c[k] = lv2_c[k] | t;
      end
    end
  end

  assign grp_cin   = {lv2_c[NG-1:1], sub_en};
  assign sum_out   = bit_p ^ bit_cin;
  assign carry_out = lv2_c[NG];
  assign ovf_out   = bit_cin[W-1] ^ lv2_c[NG];
endmodule

// File: rtl/cla_addsub_chk.sv
module cla_addsub_chk #(
  parameter int W  = 16,
  parameter int GW = 4
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         sub_en,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic         ovf_out
);
  logic [W:0]   wide;
  logic [W-1:0] be;
  logic         known;

  assign known = !$isunknown({a_in, b_in, sub_en});
  assign be    = sub_en ? ~b_in : b_in;
  assign wide  = {1'b0, a_in} + {1'b0, be} + {{W{1'b0}}, sub_en};

  always_comb begin
    if (known) begin
      // R1 R2
      a_r1_sum_value: assert (sum_out == wide[W-1:0]);
      // R3
      a_r3_carry_out: assert (carry_out == wide[W]);
      // R4
      a_r4_signed_ovf: assert (ovf_out ==
        ((a_in[W-1] == be[W-1]) && (sum_out[W-1] != a_in[W-1])));
      // R6
      if (sub_en && (a_in == b_in))
        a_r6_self_sub: assert (sum_out == '0 && carry_out && !ovf_out);
    end
  end
endmodule

bind cla_addsub cla_addsub_chk #(.W(W), .GW(GW)) u_chk (.*);

// File: tb/test_cla_addsub.sv
module test_cla_addsub;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [15:0] a16, b16, s16;
  logic        sub16, c16, v16;
  logic [7:0]  a8, b8, s8;
  logic        sub8, c8, v8;

  cla_addsub #(.W(16), .GW(4)) i_cla_addsub (
    .a_in(a16), .b_in(b16), .sub_en(sub16),
    .sum_out(s16), .carry_out(c16), .ovf_out(v16));

  cla_addsub #(.W(8), .GW(4)) i_cla_addsub_w8 (
    .a_in(a8), .b_in(b8), .sub_en(sub8),
    .sum_out(s8), .carry_out(c8), .ovf_out(v8));

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: got %0d cycles, expected under 190000", cycles);
      summary();
    end
  end

  // Result packed as {ovf, carry, sum}.
  function automatic logic [17:0] model16(logic [15:0] a, logic [15:0] b, logic s);
    int sa, sb, r;
    logic [15:0] sum;
    logic cy, ov;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (s) begin
      sum = a - b; cy = (a >= b); r = sa - sb;
    end else begin
      {cy, sum} = {1'b0, a} + {1'b0, b}; r = sa + sb;
    end
    ov = (r > 32767) || (r < -32768);
    return {ov, cy, sum};
  endfunction

  function automatic logic [9:0] model8(logic [7:0] a, logic [7:0] b, logic s);
    int sa, sb, r;
    logic [7:0] sum;
    logic cy, ov;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (s) begin
      sum = a - b; cy = (a >= b); r = sa - sb;
    end else begin
      {cy, sum} = {1'b0, a} + {1'b0, b}; r = sa + sb;
    end
    ov = (r > 127) || (r < -128);
    return {ov, cy, sum};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run16(string tag, logic [15:0] a, logic [15:0] b, logic s);
    @(posedge clk);
    a16 = a; b16 = b; sub16 = s;
    @(negedge clk);
    chk(tag, {14'd0, v16, c16, s16}, {14'd0, model16(a, b, s)});
  endtask

  initial begin
    a16 = '0; b16 = '0; sub16 = 1'b0;
    a8 = '0; b8 = '0; sub8 = 1'b0;
    @(negedge clk);
    chk("R1 idle zero inputs", {14'd0, v16, c16, s16}, 32'd0);

    run16("R5 all ones plus one", 16'hFFFF, 16'h0001, 1'b0);
    chk("R5 wrap to zero with carry", {14'd0, v16, c16, s16}, {14'd0, 2'b01, 16'h0000});
    run16("R5 max positive plus one", 16'h7FFF, 16'h0001, 1'b0);
    chk("R5 overflow to 0x8000", {14'd0, v16, c16, s16}, {14'd0, 2'b10, 16'h8000});
    run16("R4 most negative plus most negative", 16'h8000, 16'h8000, 1'b0);
    run16("R4 0 minus 0x8000", 16'h0000, 16'h8000, 1'b1);
    chk("R4 negate min overflows", {31'd0, v16}, 32'd1);
    run16("R4 0x8000 minus 1", 16'h8000, 16'h0001, 1'b1);
    run16("R4 0x7FFF minus 0xFFFF", 16'h7FFF, 16'hFFFF, 1'b1);
    run16("R6 subtract zero", 16'h1234, 16'h0000, 1'b1);
    chk("R6 subtract zero gives a", {14'd0, v16, c16, s16}, {14'd0, 2'b01, 16'h1234});
    run16("R6 self subtract", 16'hA5C3, 16'hA5C3, 1'b1);
    chk("R6 self subtract zero", {14'd0, v16, c16, s16}, {14'd0, 2'b01, 16'h0000});
    run16("R3 borrow on 1 minus 2", 16'h0001, 16'h0002, 1'b1);
    chk("R3 borrow clears carry", {31'd0, c16}, 32'd0);

    for (int k = 0; k < 16; k++) begin
      run16("R1 single carry chain", (16'hFFFF >> k), 16'h0001, 1'b0);
      run16("R2 single borrow chain", (16'h0001 << k), 16'h0001, 1'b1);
    end

    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      run16("R1 random add", ra, rb, 1'b0);
      run16("R2 random sub", ra, rb, 1'b1);
    end

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(posedge clk);
          a8 = 8'(a); b8 = 8'(b); sub8 = s[0];
          @(negedge clk);
          chk("R7 exhaustive 8-bit R3 R4", {22'd0, v8, c8, s8},
              {22'd0, model8(8'(a), 8'(b), s[0])});
        end
      end
    end

    summary();
  end
endmodule